// File: doc/BRIEF.md
# SPI Slave Firmware Download Engine

This block is an SPI slave that takes a firmware image from an external SPI master and writes it, word by word, into a RAM write port. The link runs SPI mode 0 with 8-bit transfers. SCK, chip select and MOSI are brought into the system clock domain through flop synchronisers, and the block detects SCK edges there. For this reason the system clock must run at least 8 times faster than SCK. The master may raise chip select between bytes. Doing so restarts the bit count but keeps the position in the protocol.

A download opens with a fixed header of byte slots. It holds a two-byte start marker, a 16-bit length counted in 32-bit words, the expected checksum of the payload and a byte that selects the payload slot width (1, 2 or 4 bytes per slot). The engine answers on MISO with acknowledge or reject bytes. Each answer is placed a few slots after the fields it judges. The payload follows the header, and the engine packs it into little-endian 32-bit RAM words. Two trailer slots end the transfer, and the engine reports the checksum result in them. A `done` or `error` flag then stays up until the master starts the next header.

Top module: `spi_boot_loader`

## Requirements
- R1: SPI mode 0. A MOSI bit is taken on each rising SCK edge, most significant bit first. The MISO byte for a slot is presented before that slot's first rising edge, and it moves one bit on each falling edge. MISO is 0 while chip select (`spi_cs_n`, active low) is high. Raising chip select between bytes leaves the protocol position unchanged.
- R2: Header slots 0 and 1 must carry 0x70 and 0x50. The slave returns 0x02 (accept) in slot 3 if both are correct, and 0x20 (reject) otherwise. Slot 2 carries 0x00 from the master, and its content is not judged.
- R3: After a rejected start marker, the slot 3 byte is discarded. `error` is set, no RAM write occurs, and the next byte is treated as slot 0.
- R4: Slots 3 and 4 carry the word count, low byte first. In slot 6 the slave returns 0x02 if the count is from 1 to 2^ADDR_W, and 0x20 otherwise.
- R5: Slot 6 carries the width byte: 0x00 gives 1-byte slots, 0x01 gives 2-byte slots and 0x02 gives 4-byte slots. Any other value is invalid. In slot 8 the slave returns 0x02 only if both the count and the width are valid. Otherwise the slave returns 0x20, sets `error`, makes no RAM write and goes back to slot 0.
- R6: The payload starts in slot 8 and has 4×count bytes. Inside a multi-byte slot the most significant byte comes first. Payload byte n goes to bits 8·(n mod 4)+7 : 8·(n mod 4) of RAM word n/4.
- R7: Exactly one write pulse is issued for each payload word. Addresses run 0, 1, 2 … and each write comes one clock after the byte that completes the word.
- R8: After the payload, the master sends two slots of 0x00. The slave returns 0xAA in every byte of the first slot. In every byte of the second slot it returns 0x02 if the XOR of 0xFF and all payload bytes equals the slot 5 byte, and 0x20 if it does not.
- R9: At the end of the trailer, `done` is set on a checksum match and `error` on a mismatch. The two are never high together, and both clear when the next slot 0 byte arrives.
- R10: MISO carries 0x00 in every slot not named above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock from the master, idles low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Data from the master |
| spi_miso | output | 1 | Data to the master |
| ram_we | output | 1 | One-cycle RAM write strobe |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| done | output | 1 | Download finished with a matching checksum |
| error | output | 1 | Download rejected or checksum mismatch |

## Verification
The synchroniser and edge detector put about three system clocks between an SCK edge and its effect. A byte is taken three cycles after its eighth rising edge, the RAM write follows one cycle later, and the flags one cycle after the last trailer byte. The next slot's reply is loaded on the falling edge that closes the current slot, and each later bit moves three cycles after its falling edge. For this reason the bench holds each SCK level for four system clocks and reads MISO on the falling clock edge just before it raises SCK. It reads flags and RAM contents only after the whole byte and the chip-select gap that follows it. This leaves every result at least one cycle of margin.

// File: rtl/sbl_pkg.sv
`timescale 1ns/1ps
package sbl_pkg;
  localparam int LEN_W = 16;

  localparam logic [7:0] SYNC_A    = 8'h70;
  localparam logic [7:0] SYNC_B    = 8'h50;
  localparam logic [7:0] RSP_ACK   = 8'h02;
  localparam logic [7:0] RSP_NACK  = 8'h20;
  localparam logic [7:0] RSP_FILL  = 8'hAA;
  localparam logic [7:0] CSUM_SEED = 8'hFF;

  typedef enum logic [1:0] {PH_HDR, PH_DATA, PH_TAIL} phase_t;

  // Byte position within a word arrives in wire order; XOR with this mask
  // gives the RAM lane (slot width 1, 2, 4 bytes).
  function automatic logic [1:0] lane_mask(input logic [7:0] width_code);
    case (width_code)
      8'h01:   return 2'b01;
      8'h02:   return 2'b11;
      default: return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/sbl_sync.sv
`timescale 1ns/1ps
module sbl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  input  logic cs_n_in,
  input  logic mosi_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic mosi_q
);
  logic [STAGES-1:0] sck_r, cs_r, mosi_r;
  logic              sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_r  <= '0;
      cs_r   <= '1;
      mosi_r <= '0;
      sck_d  <= 1'b0;
    end else begin
      sck_r  <= {sck_r[STAGES-2:0], sck_in};
      cs_r   <= {cs_r[STAGES-2:0], cs_n_in};
      mosi_r <= {mosi_r[STAGES-2:0], mosi_in};
      sck_d  <= sck_r[STAGES-1];
    end
  end

  assign sck_rise = sck_r[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_r[STAGES-1] & sck_d;
  assign cs_act   = ~cs_r[STAGES-1];
  assign mosi_q   = mosi_r[STAGES-1];
endmodule

// File: rtl/sbl_shift.sv
`timescale 1ns/1ps
module sbl_shift (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       cs_act,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       miso
);
  logic [2:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh;
  logic       load_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      load_pend <= 1'b0;
      rx_valid  <= 1'b0;
      rx_byte   <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
      end else begin
        if (sck_rise) begin
          rx_sh <= {rx_sh[6:0], mosi};
          if (bit_cnt == 3'd7) begin
            rx_valid  <= 1'b1;
            rx_byte   <= {rx_sh[6:0], mosi};
            load_pend <= 1'b1;
            bit_cnt   <= '0;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
          end
        end
        if (sck_fall) begin
          if (load_pend) begin
            tx_sh     <= tx_byte;
            load_pend <= 1'b0;
          end else begin
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso = cs_act & tx_sh[7];
endmodule

// File: rtl/sbl_ctrl.sv
`timescale 1ns/1ps
module sbl_ctrl
  import sbl_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic [7:0]        tx_byte,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [31:0]       ram_wdata,
  output logic              done,
  output logic              error
);
  localparam int BC_W = LEN_W + 2;
  localparam logic [LEN_W:0] DEPTH_L = (LEN_W+1)'(2**ADDR_W);

  phase_t            phase;
  logic [3:0]        hs;
  logic              pre0_ok, pre_ok, len_ok, mode_ok;
  logic [LEN_W-1:0]  len;
  logic [7:0]        csum, csum_exp;
  logic [1:0]        mask;
  logic [BC_W-1:0]   bcnt;
  logic [2:0]        tcnt;
  logic [31:0]       wbuf, word_nxt;

  logic [LEN_W:0]    len_in;
  logic              len_ok_n, last_byte, take, tail_last, tail_fill;
  logic [1:0]        lane;
  logic [2:0]        width_b;

  always_comb begin
    len_in    = {1'b0, rx_byte, len[7:0]};
    len_ok_n  = (len_in != '0) && (len_in <= DEPTH_L);
    last_byte = (bcnt == ({len, 2'b00} - BC_W'(1)));
    lane      = bcnt[1:0] ^ mask;
    word_nxt  = wbuf;
    word_nxt[{lane, 3'b000} +: 8] = rx_byte;
    width_b   = {1'b0, mask} + 3'd1;
    tail_last = ({1'b0, tcnt} == ({width_b, 1'b0} - 4'd1));
    tail_fill = (({1'b0, tcnt} + 4'd1) < {1'b0, width_b});
    take      = rx_valid &&
                (((phase == PH_HDR) && (hs == 4'd8) && len_ok && mode_ok) ||
                 (phase == PH_DATA));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_HDR;
      hs        <= '0;
      pre0_ok   <= 1'b0;
      pre_ok    <= 1'b0;
      len_ok    <= 1'b0;
      mode_ok   <= 1'b0;
      len       <= '0;
      csum      <= CSUM_SEED;
      csum_exp  <= '0;
      mask      <= '0;
      bcnt      <= '0;
      tcnt      <= '0;
      wbuf      <= '0;
      tx_byte   <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      ram_we <= 1'b0;
      if (take) begin
        csum <= csum ^ rx_byte;
        wbuf <= word_nxt;
        bcnt <= bcnt + BC_W'(1);
        if (bcnt[1:0] == 2'b11) begin
          ram_we    <= 1'b1;
          ram_addr  <= bcnt[ADDR_W+1:2];
          ram_wdata <= word_nxt;
        end
        if (last_byte) begin
          phase   <= PH_TAIL;
          tcnt    <= '0;
          tx_byte <= RSP_FILL;
        end else begin
          phase   <= PH_DATA;
          tx_byte <= 8'h00;
        end
      end else if (rx_valid) begin
        if (phase == PH_TAIL) begin
          if (tail_last) begin
            done    <= (csum == csum_exp);
            error   <= (csum != csum_exp);
            phase   <= PH_HDR;
            hs      <= '0;
            tx_byte <= 8'h00;
          end else begin
            tcnt    <= tcnt + 3'd1;
            tx_byte <= tail_fill ? RSP_FILL :
                       ((csum == csum_exp) ? RSP_ACK : RSP_NACK);
          end
        end else begin
          case (hs)
            4'd0: begin
              pre0_ok <= (rx_byte == SYNC_A);
              done    <= 1'b0;
              error   <= 1'b0;
              csum    <= CSUM_SEED;
              bcnt    <= '0;
              hs      <= 4'd1;
              tx_byte <= 8'h00;
            end
            4'd1: begin
              pre_ok  <= pre0_ok && (rx_byte == SYNC_B);
              hs      <= 4'd2;
              tx_byte <= 8'h00;
            end
            4'd2: begin
              tx_byte <= pre_ok ? RSP_ACK : RSP_NACK;
              hs      <= 4'd3;
            end
            4'd3: begin
              if (pre_ok) begin
                len[7:0] <= rx_byte;
                hs       <= 4'd4;
              end else begin
                error <= 1'b1;
                hs    <= '0;
              end
              tx_byte <= 8'h00;
            end
            4'd4: begin
              len[LEN_W-1:8] <= rx_byte;
              len_ok         <= len_ok_n;
              hs             <= 4'd5;
              tx_byte        <= 8'h00;
            end
            4'd5: begin
              csum_exp <= rx_byte;
              tx_byte  <= len_ok ? RSP_ACK : RSP_NACK;
              hs       <= 4'd6;
            end
            4'd6: begin
              mode_ok <= (rx_byte <= 8'h02);
              mask    <= lane_mask(rx_byte);
              tx_byte <= 8'h00;
              hs      <= 4'd7;
            end
            4'd7: begin
              tx_byte <= (len_ok && mode_ok) ? RSP_ACK : RSP_NACK;
              hs      <= 4'd8;
            end
            default: begin
              // slot 8 reached with a rejected header
              error   <= 1'b1;
              hs      <= '0;
              tx_byte <= 8'h00;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_boot_loader.sv
`timescale 1ns/1ps
module spi_boot_loader #(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [31:0]       ram_wdata,
  output logic              done,
  output logic              error
);
  logic       w_rise, w_fall, w_cs_act, w_mosi;
  logic       w_rx_valid;
  logic [7:0] w_rx_byte, w_tx_byte;

  sbl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sck_in   (spi_sck),
    .cs_n_in  (spi_cs_n),
    .mosi_in  (spi_mosi),
    .sck_rise (w_rise),
    .sck_fall (w_fall),
    .cs_act   (w_cs_act),
    .mosi_q   (w_mosi)
  );

  sbl_shift u_shift (
    .clk      (clk),
    .rst      (rst),
    .sck_rise (w_rise),
    .sck_fall (w_fall),
    .cs_act   (w_cs_act),
    .mosi     (w_mosi),
    .tx_byte  (w_tx_byte),
    .rx_valid (w_rx_valid),
    .rx_byte  (w_rx_byte),
    .miso     (spi_miso)
  );

  sbl_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (w_rx_valid),
    .rx_byte   (w_rx_byte),
    .tx_byte   (w_tx_byte),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .done      (done),
    .error     (error)
  );
endmodule

// File: rtl/sbl_chk.sv
`timescale 1ns/1ps
module sbl_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              done,
  input logic              error
);
  logic [ADDR_W-1:0] exp_addr;

  always_ff @(posedge clk) begin
    if (rst || done || error) exp_addr <= '0;
    else if (ram_we)          exp_addr <= ram_addr + ADDR_W'(1);
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(done && error)); // R9
  AST_FLAG_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(rx_valid)); // R9
  AST_ADDR_SEQUENCE: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr == exp_addr)); // R7
  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we); // R7
  AST_WRITE_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(rx_valid)); // R7
  AST_NO_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (done || error) |-> !ram_we); // R5
endmodule

bind spi_boot_loader sbl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rx_valid (w_rx_valid),
  .ram_we   (ram_we),
  .ram_addr (ram_addr),
  .done     (done),
  .error    (error)
);

// File: tb/spi_boot_loader_tb.sv
`timescale 1ns/1ps
module spi_boot_loader_tb;
  localparam int AW    = 4;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, ram_we, done, error;
  logic [AW-1:0] ram_addr;
  logic [31:0]   ram_wdata;

  spi_boot_loader #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .done(done), .error(error)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [0:DEPTH-1];
  int wcount = 0;
  logic clr = 1'b0;
  logic [7:0] pay [0:63];

  always @(posedge clk) begin
    if (clr) begin
      wcount <= 0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= 32'hDEADBEEF;
    end else if (ram_we) begin
      mem[ram_addr] <= ram_wdata;
      wcount <= wcount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] r);
    logic [7:0] tmp;
    tmp = 8'h00;
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      mosi = t[i];
      repeat (4) @(negedge clk);
      tmp[i] = miso;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    r = tmp;
  endtask

  task automatic session(input int sid, input logic [7:0] p0, input logic [7:0] p1,
                         input logic [7:0] mode, input int len, input bit bad_cs);
    logic [7:0] hdr [0:7];
    logic [7:0] resp [0:8];
    logic [7:0] r, cs, exp_r, bad_r;
    logic [31:0] ew;
    bit ok_pre, hdr_ok, good;
    int n, w, mask;
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    n = (len >= 1 && len <= DEPTH) ? 4 * len : 0;
    cs = 8'hFF;
    for (int i = 0; i < n; i++) begin
      pay[i] = 8'((i * 37 + sid * 11 + 5) & 255);
      cs = cs ^ pay[i];
    end
    if (bad_cs) cs = cs ^ 8'h01;
    hdr[0] = p0; hdr[1] = p1; hdr[2] = 8'h00;
    hdr[3] = 8'(len & 255); hdr[4] = 8'((len >> 8) & 255);
    hdr[5] = cs; hdr[6] = mode; hdr[7] = 8'h00;
    ok_pre = (p0 == 8'h70) && (p1 == 8'h50);

    for (int s = 0; s < 4; s++) begin
      xfer(hdr[s], resp[s]);
      if (s == 0) check(!done && !error, "R9 flags cleared by slot 0",
                        {30'd0, done, error}, 32'd0);
    end
    check(resp[3] == (ok_pre ? 8'h02 : 8'h20), "R2 start marker reply",
          resp[3], ok_pre ? 8'h02 : 8'h20);
    if (!ok_pre) begin
      check(error && !done, "R3 error after bad marker", {30'd0, done, error}, 32'd1);
      check(wcount == 0, "R3 no writes", wcount, 0);
      return;
    end
    for (int s = 4; s < 8; s++) xfer(hdr[s], resp[s]);
    hdr_ok = (n != 0) && (mode <= 8'h02);
    check(resp[6] == ((n != 0) ? 8'h02 : 8'h20), "R4 length reply",
          resp[6], (n != 0) ? 8'h02 : 8'h20);
    check(resp[4] == 8'h00 && resp[5] == 8'h00 && resp[7] == 8'h00,
          "R10 idle header slots", {resp[4], resp[5], resp[7]}, 0);
    xfer(hdr_ok ? pay[0] : 8'h5A, resp[8]);
    check(resp[8] == (hdr_ok ? 8'h02 : 8'h20), "R5 header reply",
          resp[8], hdr_ok ? 8'h02 : 8'h20);
    if (!hdr_ok) begin
      check(error && !done, "R5 error after rejected header", {30'd0, done, error}, 32'd1);
      check(wcount == 0, "R5 no writes", wcount, 0);
      return;
    end

    good = 1'b1; bad_r = 8'h00;
    for (int i = 1; i < n; i++) begin
      xfer(pay[i], r);
      if (r != 8'h00) begin good = 1'b0; bad_r = r; end
    end
    check(good, "R10 payload replies", bad_r, 0);
    check(miso == 1'b0, "R1 MISO low while deselected", miso, 0);

    w    = (mode == 8'h01) ? 2 : (mode == 8'h02) ? 4 : 1;
    mask = (mode == 8'h01) ? 1 : (mode == 8'h02) ? 3 : 0;
    good = 1'b1; bad_r = 8'h00; exp_r = 8'h00;
    for (int j = 0; j < 2 * w; j++) begin
      xfer(8'h00, r);
      if (r != ((j < w) ? 8'hAA : (bad_cs ? 8'h20 : 8'h02))) begin
        good = 1'b0; bad_r = r; exp_r = (j < w) ? 8'hAA : (bad_cs ? 8'h20 : 8'h02);
      end
    end
    check(good, "R8 trailer replies", bad_r, exp_r);
    check(done == !bad_cs && error == bad_cs, "R9 final flags",
          {30'd0, done, error}, bad_cs ? 32'd1 : 32'd2);
    check(wcount == len, "R7 write count", wcount, len);
    for (int k = 0; k < len; k++) begin
      for (int l = 0; l < 4; l++) ew[8*l +: 8] = pay[4*k + (l ^ mask)];
      check(mem[k] == ew, "R6 word packing", mem[k], ew);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lens [0:3];
    int sid;
    lens[0] = 1; lens[1] = 2; lens[2] = 7; lens[3] = 16;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!done && !error && !ram_we && !miso, "R9 reset state",
          {28'd0, done, error, ram_we, miso}, 0);
    sid = 0;
    for (int m = 0; m < 3; m++) begin
      for (int li = 0; li < 4; li++) begin
        session(sid, 8'h70, 8'h50, 8'(m), lens[li], 1'b0); // R6 R7 R8 sweep
        sid++;
      end
    end
    session(sid++, 8'h70, 8'h50, 8'h01, 5, 1'b1);   // R8 R9 bad checksum
    session(sid++, 8'h70, 8'h50, 8'h02, 3, 1'b1);
    session(sid++, 8'h71, 8'h50, 8'h00, 2, 1'b0);   // R3 bad first marker
    session(sid++, 8'h70, 8'h51, 8'h00, 2, 1'b0);   // R3 bad second marker
    session(sid++, 8'h70, 8'h50, 8'h03, 4, 1'b0);   // R5 reserved width
    session(sid++, 8'h70, 8'h50, 8'h80, 2, 1'b0);   // R5 invalid width
    session(sid++, 8'h70, 8'h50, 8'h00, 0, 1'b0);   // R4 zero length
    session(sid++, 8'h70, 8'h50, 8'h02, 17, 1'b0);  // R4 too long
    session(sid++, 8'h70, 8'h50, 8'h00, 3, 1'b0);   // recovery
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule